// File: doc/BRIEF.md
# Multi-channel start/stop window PWM

This block generates pulse-width modulated outputs on several channels from one shared counter. The counter advances on each qualified tick while the global enable is high. It climbs from zero to a programmable maximum count and then returns to zero, so one pass is one PWM period. Each channel sets its pulse with two positions inside that period. The output rises when the counter reaches the start position and falls when the counter reaches the stop position.

Software writes and reads the maximum count and the per-channel positions through a small register port. Written values are held in shadow storage. They move into the working copies only when the counter wraps, or at any time while the block is disabled, so a period never mixes old and new settings. Two settings have a fixed result. Equal start and stop positions hold the output low. A stop position beyond the maximum count holds the output high.

Top module: `win_pwm`

## Requirements
- R1: After reset all outputs are low, and every register reads back as zero.
- R2: The register map has one 16-bit word per address. Address 0 holds the maximum count. Address 1+2c holds the start position of channel c, and address 2+2c holds its stop position. Only bits 9:0 are stored. Bits 15:10 are discarded on write and read as zero. Unmapped addresses read as zero.
- R3: While enabled, the counter steps by one on each cycle with the tick input high. After it reaches the active maximum count, the next tick returns it to zero. The period is therefore maximum+1 ticks, and a maximum of zero gives a period of one tick.
- R4: With start < stop ≤ maximum, a channel is high while the counter lies in [start, stop).
- R5: With start > stop and stop ≤ maximum, a channel is high while the counter is ≥ start or < stop. The pulse wraps across the period boundary.
- R6: With start equal to stop, a channel stays low. This rule takes priority over R7.
- R7: With a stop position greater than the active maximum count, and a start position that differs from it, a channel stays high.
- R8: A written value does not change the behaviour of the running period. Written maximum, start and stop values take effect together in the cycle the counter wraps to zero.
- R9: While the enable is low, the counter is held at zero, all outputs are low, and written values are loaded at once into the working copies.
- R10: Outputs are registered. A channel's output reflects the counter value and the settings that were present one clock earlier.
- R11: Channels are independent. Each channel's output depends only on its own start and stop positions, the shared counter and the shared maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Global enable |
| tick_i | input | 1 | Count qualifier, one cycle per counter step |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i, shadow value, combinational |
| pwm_o | output | 4 | Channel outputs |

## Verification
The hardest case to reach is a write that lands in the middle of a period. The value must stay invisible until the counter wraps. It is harder still when the maximum count shrinks below the current counter value, or below a channel's stop position, at the same moment. The stimulus rewrites the maximum and a channel's positions while the counter runs, both with dense ticks and with ticks on one cycle in three. The reference model tracks the shadow and working copies separately and checks every output on every clock. The stimulus also covers equal positions, stop positions beyond the maximum, wrapped pulses, a maximum of zero, and toggling of the enable.

// File: rtl/win_pwm_pkg.sv
package win_pwm_pkg;
  localparam int unsigned DATA_W = 16;

  // Register map: address 0 holds the maximum count, then channel c uses a pair of words.
  function automatic int unsigned start_addr(int unsigned ch);
    return 1 + 2 * ch;
  endfunction

  function automatic int unsigned stop_addr(int unsigned ch);
    return 2 + 2 * ch;
  endfunction
endpackage

// File: rtl/win_pwm_regs.sv
module win_pwm_regs
  import win_pwm_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 10,
  parameter int unsigned AW  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [AW-1:0]           addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  output logic [CW-1:0]           sh_max_o,
  output logic [NCH-1:0][CW-1:0]  sh_start_o,
  output logic [NCH-1:0][CW-1:0]  sh_stop_o
);
  logic [CW-1:0] max_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         max_q <= '0;
    else if (we_i && addr_i == AW'(0))   max_q <= wdata_i[CW-1:0];
  end
  assign sh_max_o = max_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [AW-1:0] A_ST = AW'(start_addr(c));
    localparam logic [AW-1:0] A_SP = AW'(stop_addr(c));
    logic [CW-1:0] st_q, sp_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q <= '0;
        sp_q <= '0;
      end else if (we_i) begin
        if (addr_i == A_ST) st_q <= wdata_i[CW-1:0];
        if (addr_i == A_SP) sp_q <= wdata_i[CW-1:0];
      end
    end
    assign sh_start_o[c] = st_q;
    assign sh_stop_o[c]  = sp_q;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AW'(0)) rdata_o[CW-1:0] = max_q;
    for (int unsigned c = 0; c < NCH; c++) begin
      if (addr_i == AW'(start_addr(c))) rdata_o[CW-1:0] = sh_start_o[c];
      if (addr_i == AW'(stop_addr(c)))  rdata_o[CW-1:0] = sh_stop_o[c];
    end
  end
endmodule

// File: rtl/win_pwm_timebase.sv
module win_pwm_timebase #(
  parameter int unsigned CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic [CW-1:0] sh_max_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] act_max_o,
  output logic          load_o
);
  logic [CW-1:0] cnt_q, max_q;
  logic          at_top;

  assign at_top = (cnt_q == max_q);
  // Working copies refresh on wrap, or continuously while disabled.
  assign load_o = !en_i || (tick_i && at_top);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      max_q <= '0;
    end else begin
      if (load_o) begin
        cnt_q <= '0;
        max_q <= sh_max_i;
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign act_max_o = max_q;
endmodule

// File: rtl/win_pwm_chan.sv
module win_pwm_chan #(
  parameter int unsigned CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  input  logic [CW-1:0] sh_start_i,
  input  logic [CW-1:0] sh_stop_i,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] act_max_i,
  output logic          pwm_o
);
  logic [CW-1:0] st_q, sp_q;
  logic          lvl, pwm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
      sp_q <= '0;
    end else if (load_i) begin
      st_q <= sh_start_i;
      sp_q <= sh_stop_i;
    end
  end

  always_comb begin
    if (st_q == sp_q)          lvl = 1'b0;   // equal wins over beyond-max
    else if (sp_q > act_max_i) lvl = 1'b1;
    else if (st_q < sp_q)      lvl = (cnt_i >= st_q) && (cnt_i < sp_q);
    else                       lvl = (cnt_i >= st_q) || (cnt_i < sp_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= en_i && lvl;
  end

  assign pwm_o = pwm_q;
endmodule

// File: rtl/win_pwm.sv
module win_pwm
  import win_pwm_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 10,
  localparam int unsigned AW = $clog2(2 * NCH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [NCH-1:0]    pwm_o
);
  logic [CW-1:0]          sh_max;
  logic [NCH-1:0][CW-1:0] sh_start, sh_stop;
  logic [CW-1:0]          cnt, act_max;
  logic                   load;

  win_pwm_regs #(.NCH(NCH), .CW(CW), .AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .sh_max_o(sh_max), .sh_start_o(sh_start), .sh_stop_o(sh_stop)
  );

  win_pwm_timebase #(.CW(CW)) u_tb (
    .clk_i, .rst_ni, .en_i, .tick_i,
    .sh_max_i(sh_max), .cnt_o(cnt), .act_max_o(act_max), .load_o(load)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    win_pwm_chan #(.CW(CW)) u_chan (
      .clk_i, .rst_ni, .en_i, .load_i(load),
      .sh_start_i(sh_start[c]), .sh_stop_i(sh_stop[c]),
      .cnt_i(cnt), .act_max_i(act_max), .pwm_o(pwm_o[c])
    );
  end
endmodule

// File: rtl/win_pwm_chk.sv
module win_pwm_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 10,
  parameter int unsigned DW  = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           en_i,
  input logic           tick_i,
  input logic [NCH-1:0] pwm_o,
  input logic [DW-1:0]  rdata,
  input logic [CW-1:0]  cnt,
  input logic [CW-1:0]  act_max,
  input logic           load
);
  assert_dis_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> pwm_o == '0);
  assert_dis_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt == '0);
  assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && tick_i && cnt != act_max |=> cnt == $past(cnt) + 1'b1);
  assert_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && tick_i && cnt == act_max |=> cnt == '0);
  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !tick_i |=> $stable(cnt));
  assert_max_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(act_max));
  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata[DW-1:CW] == '0);
endmodule

bind win_pwm win_pwm_chk #(.NCH(NCH), .CW(CW), .DW(win_pwm_pkg::DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .tick_i(tick_i), .pwm_o(pwm_o),
  .rdata(reg_rdata_o), .cnt(cnt), .act_max(act_max), .load(load)
);

// File: tb/sim_win_pwm.sv
module sim_win_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, tick = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  pwm;

  always #2 clk = ~clk;

  win_pwm u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .pwm_o(pwm)
  );

  int n_chk = 0, n_fail = 0;
  string tag = "R1";

  // Reference model state
  int m_cnt = 0, a_max = 0, s_max = 0;
  int a_st[4] = '{default: 0}, a_sp[4] = '{default: 0};
  int s_st[4] = '{default: 0}, s_sp[4] = '{default: 0};
  logic [3:0] m_pwm = '0;

  function automatic bit chan_high(int c);
    if (a_st[c] == a_sp[c]) return 0;
    if (a_sp[c] > a_max) return 1;
    if (a_st[c] < a_sp[c]) return (m_cnt >= a_st[c]) && (m_cnt < a_sp[c]);
    return (m_cnt >= a_st[c]) || (m_cnt < a_sp[c]);
  endfunction

  function automatic int shadow_of(int a);
    if (a == 0) return s_max;
    for (int c = 0; c < 4; c++) begin
      if (a == 1 + 2 * c) return s_st[c];
      if (a == 2 + 2 * c) return s_sp[c];
    end
    return 0;
  endfunction

  task automatic model_step();
    logic [3:0] nxt;
    bit ld;
    for (int c = 0; c < 4; c++) nxt[c] = en && chan_high(c);
    ld = !en || (tick && m_cnt == a_max);
    if (ld) m_cnt = 0;
    else if (tick) m_cnt++;
    if (ld) begin
      a_max = s_max;
      for (int c = 0; c < 4; c++) begin a_st[c] = s_st[c]; a_sp[c] = s_sp[c]; end
    end
    if (we) begin
      if (addr == 0) s_max = wdata & 16'h3FF;
      for (int c = 0; c < 4; c++) begin
        if (addr == 1 + 2 * c) s_st[c] = wdata & 16'h3FF;
        if (addr == 2 + 2 * c) s_sp[c] = wdata & 16'h3FF;
      end
    end
    m_pwm = nxt;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (pwm !== m_pwm) begin
      n_fail++;
      $display("FAIL %s pwm_o actual=%b expected=%b", tag, pwm, m_pwm);
    end
  endtask

  task automatic wr(int a, logic [15:0] d);
    we = 1'b1; addr = 4'(a); wdata = d;
    cyc();
    we = 1'b0;
  endtask

  task automatic rd_check(int a);
    addr = 4'(a);
    #1;
    n_chk++;
    if (rdata !== 16'(shadow_of(a))) begin
      n_fail++;
      $display("FAIL %s read addr %0d actual=%h expected=%h", tag, a, rdata, 16'(shadow_of(a)));
    end
  endtask

  // mode 0: tick every cycle, else every mode-th cycle
  task automatic run(int n, int mode);
    for (int i = 0; i < n; i++) begin
      tick = (mode == 0) ? 1'b1 : ((i % mode) == 0);
      cyc();
    end
    tick = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    tag = "R1 reset";
    n_chk++;
    if (pwm !== 4'b0) begin
      n_fail++;
      $display("FAIL R1 pwm_o actual=%b expected=0000", pwm);
    end
    for (int a = 0; a < 16; a++) rd_check(a);

    tag = "R2 regmap";
    wr(0, 16'd9);
    wr(1, 16'd2);  wr(2, 16'd6);       // ch0 R4
    wr(3, 16'd7);  wr(4, 16'd3);       // ch1 R5
    wr(5, 16'd4);  wr(6, 16'd4);       // ch2 R6
    wr(7, 16'd1);  wr(8, 16'hFC0C);    // ch3 R7, upper bits discarded -> 12
    wr(11, 16'h0155);                  // unmapped
    for (int a = 0; a < 16; a++) rd_check(a);

    tag = "R3 R4 R5 R6 R7 R10 R11 dense ticks";
    en = 1'b1;
    run(35, 0);
    tag = "R3 R10 sparse ticks";
    run(45, 3);

    tag = "R8 shadow mid-period";
    tick = 1'b1; cyc(); cyc(); cyc();
    wr(1, 16'd0); wr(2, 16'd9);
    wr(0, 16'd5);
    wr(5, 16'd3); wr(6, 16'd5);
    rd_check(0);
    run(40, 0);
    run(30, 2);

    tag = "R9 disable";
    tick = 1'b1;
    cyc();
    en = 1'b0;
    wr(0, 16'd7);
    run(8, 0);
    en = 1'b1;
    run(25, 0);

    tag = "R3 R6 R7 max zero";
    wr(0, 16'd0);
    wr(5, 16'd0); wr(6, 16'd0);
    run(30, 0);
    run(12, 4);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule